// File: doc/BRIEF.md
# Streaming Allocation/Release Pairing Monitor

This block watches a live stream of memory-management events and reports, one cycle after each event, whether that event breaks the pairing rule between allocations and releases. Each event is either an allocation or a release of one address. The property checked is past-time: a release of an address is legal only if that address has not been released again since it was last allocated. The "always held in the past" value is kept incrementally. It starts true, and at each step it is the previous value ANDed with the current step's condition. No trace is buffered.

Each address is a bound variable and needs its own automaton. The monitor keeps a fixed table of slots, and each slot holds a valid bit, an address and a one-bit automaton state (live or released). An event's address is looked up associatively in every slot in parallel. A new address claims a slot on demand. A released slot stays in the table so that a second release can be caught, and it may later be reclaimed for a new address. When nothing can be claimed, the allocation raises a table-overflow flag and is otherwise dropped.

The event input is a valid/ready stream. The monitor applies no back-pressure beyond reset: `ev_ready` is low while `rst_n` is low and high at all other times. An event is accepted on any clock edge where `ev_valid` and `ev_ready` are both high. The producer must hold `ev_op` and `ev_addr` stable while `ev_valid` is high and `ev_ready` is low. The violation and overflow outputs are plain registered strobes with no handshake.

Top module: `alloc_pair_monitor`

## Requirements
- R1: `ev_ready` is 0 while `rst_n` is 0 and 1 otherwise. Every edge with `ev_valid`=1 and `ev_ready`=1 consumes exactly one event. `ev_op`=0 means allocate and `ev_op`=1 means release.
- R2: Allocating an address that is in no valid slot claims a slot in the live state and produces no violation. A later release of that address produces no violation.
- R3: An allocation of an absent address when every slot is valid and live raises `overflow` for exactly one cycle. It raises no violation and leaves the table unchanged, so a later release of that address reports kind 3.
- R4: Allocating an address whose slot is live reports kind 1 (repeated allocation) and leaves the slot live, so a following release is legal.
- R5: Releasing an address whose slot is in the released state reports kind 2 (repeated release).
- R6: Releasing an address found in no valid slot reports kind 3 (release of an unknown address).
- R7: Allocating an address whose slot is in the released state makes that same slot live again with no violation, and the next release of it is legal.
- R8: A new address claims the lowest-index invalid slot. If no slot is invalid, it takes the lowest-index slot in the released state, and the evicted address is forgotten, so releasing it afterwards reports kind 3.
- R9: `viol_valid`, `viol_kind`, `viol_addr` and `overflow` change one clock edge after the event is accepted. `viol_addr` equals the event's address. `viol_kind` is 0 whenever `viol_valid` is 0. A cycle with no accepted event produces no strobe. `viol_valid` and `overflow` are never high together.
- R10: Reset empties every slot and clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Monitor accepts an event |
| ev_op | input | 1 | 0 allocate, 1 release |
| ev_addr | input | AW (32) | Event address |
| viol_valid | output | 1 | Violation strobe |
| viol_kind | output | 2 | 1 repeated allocation, 2 repeated release, 3 unknown release |
| viol_addr | output | AW (32) | Address of the offending event |
| overflow | output | 1 | Allocation dropped because the table is full |

## Verification
Every cycle, the assertions check timing and consistency at the outputs. A strobe only follows an accepted event and carries that event's address. Each violation kind only follows the opcode that can cause it. A violation and an overflow never coincide, and the kind is zero when idle. Whether the correct kind was reported depends on the table's history, and only the bench's scenarios can show that. These scenarios cover slot reclaim order, eviction, re-allocation of released addresses, overflow leaving the table untouched, and reset emptying the table. They are compared cycle by cycle against a behavioural model.

// File: rtl/alloc_pair_pkg.sv
package alloc_pair_pkg;
  typedef enum logic { OP_ALLOC = 1'b0, OP_RELEASE = 1'b1 } ev_op_e;
  typedef enum logic [1:0] {
    VK_NONE       = 2'd0,
    VK_DUP_ALLOC  = 2'd1,
    VK_DUP_FREE   = 2'd2,
    VK_STRAY_FREE = 2'd3
  } viol_kind_e;
endpackage

// File: rtl/apm_match.sv
module apm_match #(
  parameter int SLOTS = 16,
  parameter int AW    = 32
) (
  input  logic [SLOTS-1:0]         slot_vld,
  input  logic [SLOTS-1:0][AW-1:0] slot_addr,
  input  logic [AW-1:0]            key,
  output logic [SLOTS-1:0]         hit
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit[g] = slot_vld[g] && (slot_addr[g] == key);
  end
endmodule

// File: rtl/apm_pick.sv
module apm_pick #(
  parameter int SLOTS = 16
) (
  input  logic [SLOTS-1:0] cand,
  output logic [SLOTS-1:0] grant,
  output logic             any
);
  always_comb begin
    grant = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
  assign any = |cand;
endmodule

// File: rtl/apm_table.sv
module apm_table #(
  parameter int SLOTS = 16,
  parameter int AW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SLOTS-1:0]         wr_sel,
  input  logic [AW-1:0]            wr_addr,
  input  logic                     wr_live,
  output logic [SLOTS-1:0]         slot_vld,
  output logic [SLOTS-1:0]         slot_live,
  output logic [SLOTS-1:0][AW-1:0] slot_addr
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[g]  <= 1'b0;
        slot_live[g] <= 1'b0;
        slot_addr[g] <= '0;
      end else if (wr_en && wr_sel[g]) begin
        slot_vld[g]  <= 1'b1;
        slot_live[g] <= wr_live;
        slot_addr[g] <= wr_addr;
      end
    end
  end
endmodule

// File: rtl/alloc_pair_monitor.sv
module alloc_pair_monitor
  import alloc_pair_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic          ev_op,
  input  logic [AW-1:0] ev_addr,
  output logic          viol_valid,
  output logic [1:0]    viol_kind,
  output logic [AW-1:0] viol_addr,
  output logic          overflow
);
  logic [SLOTS-1:0]         slot_vld, slot_live, hit;
  logic [SLOTS-1:0][AW-1:0] slot_addr;
  logic [SLOTS-1:0]         g_empty, g_spare;
  logic                     any_empty, any_spare;
  logic                     accept, hit_any, hit_live;
  logic                     wr_en, wr_live, ovf_d;
  logic [SLOTS-1:0]         wr_sel;
  viol_kind_e               kind_d;

  assign ev_ready = rst_n;
  assign accept   = ev_valid && ev_ready;

  apm_match #(.SLOTS(SLOTS), .AW(AW)) u_match (
    .slot_vld(slot_vld), .slot_addr(slot_addr), .key(ev_addr), .hit(hit)
  );

  apm_pick #(.SLOTS(SLOTS)) u_pick_empty (
    .cand(~slot_vld), .grant(g_empty), .any(any_empty)
  );

  apm_pick #(.SLOTS(SLOTS)) u_pick_spare (
    .cand(slot_vld & ~slot_live), .grant(g_spare), .any(any_spare)
  );

  assign hit_any  = |hit;
  assign hit_live = |(hit & slot_live);

  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = '0;
    wr_live = 1'b0;
    ovf_d   = 1'b0;
    kind_d  = VK_NONE;
    if (accept) begin
      if (ev_op == OP_ALLOC) begin
        if (hit_live) begin
          kind_d = VK_DUP_ALLOC;
        end else if (hit_any) begin
          wr_en = 1'b1; wr_sel = hit; wr_live = 1'b1;
        end else if (any_empty) begin
          wr_en = 1'b1; wr_sel = g_empty; wr_live = 1'b1;
        end else if (any_spare) begin
          wr_en = 1'b1; wr_sel = g_spare; wr_live = 1'b1;
        end else begin
          ovf_d = 1'b1;
        end
      end else begin
        if (hit_live) begin
          wr_en = 1'b1; wr_sel = hit; wr_live = 1'b0;
        end else if (hit_any) begin
          kind_d = VK_DUP_FREE;
        end else begin
          kind_d = VK_STRAY_FREE;
        end
      end
    end
  end

  apm_table #(.SLOTS(SLOTS), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(ev_addr), .wr_live(wr_live),
    .slot_vld(slot_vld), .slot_live(slot_live), .slot_addr(slot_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_kind  <= 2'd0;
      viol_addr  <= '0;
      overflow   <= 1'b0;
    end else begin
      viol_valid <= (kind_d != VK_NONE);
      viol_kind  <= kind_d;
      viol_addr  <= (kind_d != VK_NONE) ? ev_addr : '0;
      overflow   <= ovf_d;
    end
  end
endmodule

// File: rtl/apm_checker.sv
module apm_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic          ev_op,
  input logic [AW-1:0] ev_addr,
  input logic          viol_valid,
  input logic [1:0]    viol_kind,
  input logic [AW-1:0] viol_addr,
  input logic          overflow
);
  p_viol_follows_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(ev_valid && ev_ready));
  p_viol_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> viol_addr == $past(ev_addr));
  p_idle_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid == (viol_kind != 2'd0));
  p_ovf_follows_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(ev_valid && ev_ready && !ev_op));
  p_ovf_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && viol_valid));
  p_dup_alloc_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_kind == 2'd1) |-> !$past(ev_op));
  p_dup_free_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_kind == 2'd2) |-> $past(ev_op));
  p_stray_free_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_kind == 2'd3) |-> $past(ev_op));
endmodule

bind alloc_pair_monitor apm_checker #(.AW(AW)) u_apm_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_op(ev_op), .ev_addr(ev_addr), .viol_valid(viol_valid),
  .viol_kind(viol_kind), .viol_addr(viol_addr), .overflow(overflow)
);

// File: tb/tb_alloc_pair_monitor.sv
module tb_alloc_pair_monitor;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_op = 1'b0;
  logic [31:0] ev_addr = '0;
  logic ev_ready, viol_valid, overflow;
  logic [1:0] viol_kind;
  logic [31:0] viol_addr;
  int total = 0, bad = 0;

  // behavioural reference state
  bit m_vld [N];
  bit m_live[N];
  logic [31:0] m_addr[N];
  bit e_vv, e_ovf;
  logic [1:0] e_kind;
  logic [31:0] e_addr;
  string e_tag = "R10";

  always #2 clk = ~clk;

  alloc_pair_monitor dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_op(ev_op), .ev_addr(ev_addr), .viol_valid(viol_valid),
    .viol_kind(viol_kind), .viol_addr(viol_addr), .overflow(overflow)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R1", "ev_ready", 32'(ev_ready), 32'(rst_n));
    chk(e_tag, "viol_valid", 32'(viol_valid), 32'(e_vv));
    chk(e_tag, "viol_kind", 32'(viol_kind), 32'(e_kind));
    if (e_vv) chk(e_tag, "viol_addr", viol_addr, e_addr);
    chk(e_tag, "overflow", 32'(overflow), 32'(e_ovf));
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_live[i] = 0; m_addr[i] = '0; end
  endtask

  task automatic model(input bit v, input bit op, input logic [31:0] a);
    int h, s;
    e_vv = 0; e_ovf = 0; e_kind = 2'd0; e_addr = a; e_tag = "R9";
    if (!v) return;
    h = -1;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_addr[i] == a) h = i;
    if (!op) begin
      if (h >= 0 && m_live[h]) begin e_vv = 1; e_kind = 2'd1; e_tag = "R4"; end
      else if (h >= 0) begin m_live[h] = 1; e_tag = "R7"; end
      else begin
        s = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) s = i;
        e_tag = "R2";
        if (s < 0) begin
          for (int i = N - 1; i >= 0; i--) if (!m_live[i]) s = i;
          e_tag = "R8";
        end
        if (s < 0) begin e_ovf = 1; e_tag = "R3"; end
        else begin m_vld[s] = 1; m_live[s] = 1; m_addr[s] = a; end
      end
    end else begin
      if (h >= 0 && m_live[h]) begin m_live[h] = 0; e_tag = "R2"; end
      else if (h >= 0) begin e_vv = 1; e_kind = 2'd2; e_tag = "R5"; end
      else begin e_vv = 1; e_kind = 2'd3; e_tag = "R6"; end
    end
  endtask

  // called at a falling edge; outputs there reflect the previous step's event
  task automatic step(input bit v, input bit op, input logic [31:0] a);
    check_outputs();
    ev_valid = v; ev_op = op; ev_addr = a;
    model(v, op, a);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1", "ev_ready in reset", 32'(ev_ready), 32'd0);
    chk("R10", "viol_valid in reset", 32'(viol_valid), 32'd0);
    chk("R10", "overflow in reset", 32'(overflow), 32'd0);
    chk("R10", "viol_kind in reset", 32'(viol_kind), 32'd0);
    model_clear();
    e_vv = 0; e_ovf = 0; e_kind = 0; e_tag = "R10";
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] ad(input int i);
    return 32'h0000_1000 + 32'(i) * 32'h10;
  endfunction

  initial begin : wdog
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] lf;
    model_clear();
    do_reset();
    step(0, 0, 0);
    // R2: fill all slots, check legal pairing on one address
    for (int i = 0; i < N; i++) step(1, 0, ad(i));
    step(1, 0, ad(5));              // R4 repeated allocation
    step(1, 1, ad(5));              // R4 slot stayed live: legal release
    step(1, 1, ad(5));              // R5 repeated release
    step(1, 0, ad(5));              // R7 re-allocate same slot
    step(1, 1, ad(5));              // R7 legal release
    step(1, 1, ad(99));             // R6 unknown
    step(1, 0, ad(5));              // R7 live again
    step(1, 0, ad(40));             // R3 overflow, all live
    step(0, 0, 0);                  // R9 idle
    step(1, 1, ad(40));             // R3 table unchanged -> kind 3
    step(1, 1, ad(9));              // free slot 9
    step(1, 1, ad(3));              // free slot 3
    step(1, 0, ad(41));             // R8 reclaims slot 3 (lowest)
    step(1, 1, ad(3));              // R8 evicted -> kind 3
    step(1, 1, ad(9));              // R5 slot 9 still released
    step(1, 0, ad(42));             // R8 reclaims slot 9
    step(1, 1, ad(9));              // R8 evicted
    step(1, 0, ad(43));             // R3 overflow again
    step(1, 1, ad(41));
    step(1, 1, ad(41));             // R5
    // R10: reset empties the table
    step(0, 0, 0);
    do_reset();
    step(1, 1, ad(0));              // R10 -> kind 3
    step(1, 0, ad(0));              // R2 fresh claim
    step(1, 1, ad(0));
    // mixed pattern over a pool larger than the table
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[7], lf[3] & ~lf[11], ad(int'(lf[15:8]) % 22));
    end
    step(0, 0, 0);
    step(0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule